// File: doc/BRIEF.md
# Dual-Mode Test Pattern Source

This block supplies one data word per enabled clock cycle to a memory self-test engine. A select input chooses between two sources. One is a binary up-counter. The other is a Fibonacci linear-feedback shift register (LFSR) that produces a pseudo-random sequence. The output is a plain parallel word with no handshake. It does not produce addresses, access memory or compare read data.

Each source keeps its own state register. Only the selected source advances, and it advances only on cycles where the enable is high. A write-side instance and a check-side instance that see the same reset, select and enable history therefore produce identical words.

The select input is decoded into two named source states. In `SRC_COUNT` the counter register drives the output. In `SRC_LFSR` the shift register drives the output. The select input can move the block between these states on any cycle: `rand_sel` rising moves it from `SRC_COUNT` to `SRC_LFSR`, and `rand_sel` falling moves it back. Neither move clears any state.

Top module: `pattern_source`

## Requirements
- R1: A synchronous reset loads the counter with 0 and the LFSR with the non-zero seed (default 23'h000001). After reset, `data_o` shows 0 when `rand_sel`=0 and shows the seed when `rand_sel`=1.
- R2: With `rand_sel`=0, `data_o` is 0 on the first enabled cycle after reset and rises by exactly 1 after each enabled clock edge.
- R3: On a clock edge where `en`=0, neither state register changes, so `data_o` holds its value.
- R4: With `rand_sel`=1 and `en`=1, the next word is the current word shifted left by one bit. The new bit 0 is the XOR of bit 22 and bit 17 of the current word.
- R5: With the default 23-bit configuration and `rand_sel`=1, 1024 consecutive enabled outputs are all different.
- R6: Changing `rand_sel` clears neither register, and the unselected register does not advance. Returning to a mode resumes that mode's sequence where it stopped.
- R7: The counter wraps from all ones to 0.
- R8: The LFSR never reaches the all-zero state. With a width of 7 and taps at bits 6 and 5, it returns to its seed after exactly 127 enabled steps, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the selected source on this edge |
| rand_sel | input | 1 | 0 selects the counter; 1 selects the LFSR |
| data_o | output | WIDTH (23) | Current pattern word |

## Verification
The bench builds two instances of the block.

The default instance has a width of 23 and taps at bits 22 and 17. It is used for a 1024-step counting run, a 1024-step random run checked word by word against an arithmetic model, and a pairwise distinctness check over that random run.

The second instance has a width of 7 and taps at bits 6 and 5. This small size puts the whole 128-step counter wrap and the full 127-step LFSR period within reach, so the bench sweeps both completely.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    typedef enum logic {
        SRC_COUNT = 1'b0,
        SRC_LFSR  = 1'b1
    } src_e;
endpackage

// File: rtl/tpg_counter.sv
module tpg_counter #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (step) begin
            value <= value + ONE;
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> value == $past(value) + ONE);

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(value));
endmodule

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
    parameter int          W     = 23,
    parameter int          TAP_A = 22,
    parameter int          TAP_B = 17,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] state
);
    logic fb;
    logic [W-1:0] nxt;

    always_comb begin
        fb  = state[TAP_A] ^ state[TAP_B];
        nxt = {state[W-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else if (step) begin
            state <= nxt;
        end
    end

    // R8
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    // R4
    lfsr_shift_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> state[W-1:1] == $past(state[W-2:0]));

    // R3
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state));
endmodule

// File: rtl/pattern_source.sv
module pattern_source
    import tpg_pkg::*;
#(
    parameter int           WIDTH = 23,
    parameter int           TAP_A = 22,
    parameter int           TAP_B = 17,
    parameter logic [WIDTH-1:0] SEED = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             rand_sel,
    output logic [WIDTH-1:0] data_o
);
    src_e             src;
    logic             cnt_step;
    logic             lfsr_step;
    logic [WIDTH-1:0] cnt_val;
    logic [WIDTH-1:0] lfsr_val;

    // source state decode
    always_comb begin
        src = rand_sel ? SRC_LFSR : SRC_COUNT;
    end

    // outputs and step enables per state
    always_comb begin
        cnt_step  = 1'b0;
        lfsr_step = 1'b0;
        data_o    = '0;
        unique case (src)
            SRC_COUNT: begin
                cnt_step = en;
                data_o   = cnt_val;
            end
            SRC_LFSR: begin
                lfsr_step = en;
                data_o    = lfsr_val;
            end
            default: data_o = '0;
        endcase
    end

    tpg_counter #(.W(WIDTH)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .step  (cnt_step),
        .value (cnt_val)
    );

    tpg_lfsr #(.W(WIDTH), .TAP_A(TAP_A), .TAP_B(TAP_B), .SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .step  (lfsr_step),
        .state (lfsr_val)
    );

    // R6
    one_source_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cnt_step, lfsr_step}));

    // R6
    idle_lfsr_chk: assert property (@(posedge clk) disable iff (rst)
        !rand_sel |=> $stable(lfsr_val));

    // R6
    idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        rand_sel |=> $stable(cnt_val));
endmodule

// File: tb/pattern_source_bench.sv
module pattern_source_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, rand_sel = 1'b0;
    logic en_s = 1'b0, sel_s = 1'b0;
    logic [22:0] data_o;
    logic [6:0]  data_s;
    int checks = 0, fails = 0;
    bit  done = 1'b0;
    logic [22:0] seen [1024];

    always #10 clk = ~clk;

    pattern_source u_pattern_source (
        .clk(clk), .rst(rst), .en(en), .rand_sel(rand_sel), .data_o(data_o));

    pattern_source #(.WIDTH(7), .TAP_A(6), .TAP_B(5), .SEED(7'h01)) u_small (
        .clk(clk), .rst(rst), .en(en_s), .rand_sel(sel_s), .data_o(data_s));

    function automatic logic [22:0] nxt23(logic [22:0] s);
        return {s[21:0], s[22] ^ s[17]};
    endfunction

    function automatic logic [6:0] nxt7(logic [6:0] s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [22:0] m;
        logic [6:0]  s;
        bit dup;
        @(negedge clk);
        tick();
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", data_o, 0);
        rand_sel = 1'b1; #1;
        check("R1", data_o, 23'h1);
        rand_sel = 1'b0; en = 1'b1; #1;
        // R2 counting sweep
        for (int i = 0; i < 1024; i++) begin
            check("R2", data_o, i);
            tick();
        end
        // R3 hold with enable low
        en = 1'b0; #1;
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R3", data_o, 1024);
        end
        // R6 random register untouched by counting
        rand_sel = 1'b1; #1;
        check("R6", data_o, 23'h1);
        // R4 random sweep against model
        en = 1'b1; m = 23'h1;
        for (int i = 0; i < 1024; i++) begin
            check("R4", data_o, m);
            seen[i] = data_o;
            m = nxt23(m);
            tick();
        end
        // R5 pairwise distinctness
        dup = 1'b0;
        for (int i = 0; i < 1024; i++)
            for (int j = i + 1; j < 1024; j++)
                if (seen[i] == seen[j]) dup = 1'b1;
        check("R5", dup, 0);
        // R6 counter resumes
        rand_sel = 1'b0; #1;
        check("R6", data_o, 1024);
        tick();
        check("R6", data_o, 1025);
        rand_sel = 1'b1; en = 1'b0; #1;
        check("R6", data_o, m);
        // R7 small counter wrap
        en_s = 1'b1; sel_s = 1'b0; #1;
        for (int i = 0; i < 128; i++) tick();
        check("R7", data_s, 0);
        tick();
        check("R7", data_s, 1);
        // R8 small LFSR full period
        sel_s = 1'b1; #1;
        s = 7'h01;
        check("R8", data_s, 7'h01);
        for (int i = 1; i <= 127; i++) begin
            tick();
            s = nxt7(s);
            check("R8", data_s, s);
            if (i < 127) check("R8", (data_s == 7'h01) || (data_s == 7'h00), 0);
        end
        check("R8", data_s, 7'h01);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule